// File: doc/BRIEF.md
# Row/Column Serial Command Decoder

This block turns a framed, MSB-first serial byte stream into addressed writes for a character display memory. A SPI-style front end synchronises the select, clock and data lines into the system clock domain and assembles bytes while select is held low. Each completed byte is classified by its upper bits as a row header, a column header or a data byte, and a format state machine turns the sequence into write commands that carry a plane select (character code or attribute), a row, a column and a 9-bit data word.

Three packet shapes are accepted. In the single-write shape each data byte is preceded by its own row and column header. In the per-column shape the row is kept and a column header precedes each data byte. In the burst shape a column header with its bit 6 set makes every later byte of the frame a data byte, and the column then steps forward after each write. The burst shape is left only when the frame ends.

Writes leave through a one-entry valid/ready output register. The consumer may stall by holding `wr_ready` low; the pending write then stays on the port unchanged. The serial link cannot be paused, so a write decoded while an earlier one is still pending is dropped; a consumer that accepts each write within one serial byte time never loses one.

Top module: `rc_cmd_decoder`

## Requirements
- R1: After reset `wr_valid` is 0 and no write is presented until a complete packet has been received.
- R2: Bits are taken on rising edges of `spi_sck` only while `spi_sel_n` is low, first bit into data bit 7; raising `spi_sel_n` ends the frame and puts the decoder back into its initial state.
- R3: A byte with bit 7 = 1 is a row header: bit 5 picks the plane (0 = character code, 1 = attribute) and bits 4..0 give the row; in the initial state any byte with bit 7 = 0 is ignored.
- R4: After a row header or after a data byte of the single or per-column shapes, a byte with bit 7 = 0 is a column header; bits 4..0 give the column, and bit 6 = 0 selects one following data byte.
- R5: For the character plane, bit 5 of the column header becomes data bit 8 and the data byte gives bits 7..0; for the attribute plane data bit 8 is 0.
- R6: In the single and per-column shapes a data byte produces one write at the current row and column, and the next byte may be a new row header or a new column header.
- R7: A column header with bit 6 = 1 enters burst mode: every following byte of the frame, whatever its bit 7, is data written at the current address, after which the column increments; column 31 wraps to 0 and the row increments.
- R8: In burst mode data bit 8 keeps the value latched from the column header for every byte of the frame.
- R9: Once in burst mode the decoder stays there until `spi_sel_n` rises.
- R10: If `spi_sel_n` rises with a byte partly shifted in, the partial bits are discarded and the next frame starts from the initial state.
- R11: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid` stays 1 and the write fields hold their values.
- R12: A write decoded while an earlier write is still pending is dropped and the pending write is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | Frame select, low while a frame is in progress |
| spi_sck | input | 1 | Serial bit clock, data taken on its rising edge |
| spi_mosi | input | 1 | Serial data in, MSB first |
| wr_valid | output | 1 | A write command is presented |
| wr_ready | input | 1 | Consumer accepts the presented write |
| wr_plane | output | 1 | 0 = character code plane, 1 = attribute plane |
| wr_row | output | 5 | Target row |
| wr_col | output | 5 | Target column |
| wr_data | output | 9 | Write data, bit 8 from the column header |

## Verification
The checker assumes the serial lines change slowly compared with `clk`: every `spi_sck` phase and every gap around `spi_sel_n` lasts several system clocks, and `spi_mosi` is settled before the rising `spi_sck` edge, so that the synchronised copies stay aligned. The bench drives each serial phase for eight system clocks and changes data only while `spi_sck` is low. Properties on the output register also take for granted that `wr_ready` changes only between clock edges; the bench updates it one time unit after a rising edge.

// File: rtl/rc_cmd_pkg.sv
package rc_cmd_pkg;

  localparam int ROW_W  = 5;
  localparam int COL_W  = 5;
  localparam int BYTE_W = 8;
  localparam int DATA_W = BYTE_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ROW   = 3'd1,
    ST_COL   = 3'd2,
    ST_DATA  = 3'd3,
    ST_BURST = 3'd4
  } fmt_state_e;

  typedef struct packed {
    logic              plane;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;

endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rst_val,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= rst_val;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= rst_val;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rc_spi_shifter.sv
module rc_spi_shifter
  import rc_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sel_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frame_end
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [2:0] sync_q;
  logic       s_sel_n, s_sck, s_mosi;
  logic       sck_d, sel_d;
  logic       sck_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;

  rc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (3'b100),
    .d       ({spi_sel_n, spi_sck, spi_mosi}),
    .q       (sync_q)
  );

  assign s_sel_n  = sync_q[2];
  assign s_sck    = sync_q[1];
  assign s_mosi   = sync_q[0];
  assign sck_rise = s_sck && !sck_d && !s_sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d     <= 1'b0;
      sel_d     <= 1'b1;
      frame_end <= 1'b0;
    end else begin
      sck_d     <= s_sck;
      sel_d     <= s_sel_n;
      frame_end <= s_sel_n && !sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (s_sel_n) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[BYTE_W-3:0], s_mosi};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_LAST) begin
          byte_valid <= 1'b1;
          byte_data  <= {shreg, s_mosi};
          bit_cnt    <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/rc_fmt_fsm.sv
module rc_fmt_fsm
  import rc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              frame_end,
  output logic              req_valid,
  output wr_cmd_t           req_cmd,
  output fmt_state_e        state
);

  localparam logic [COL_W-1:0] COL_LAST = '1;

  logic             plane_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             d8_q;

  logic             is_row;
  logic             is_burst;
  logic [COL_W-1:0] hdr_col;
  logic [ROW_W-1:0] hdr_row;

  assign is_row   = byte_data[7];
  assign is_burst = byte_data[6];
  assign hdr_col  = byte_data[COL_W-1:0];
  assign hdr_row  = byte_data[ROW_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      plane_q   <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      d8_q      <= 1'b0;
      req_valid <= 1'b0;
      req_cmd   <= '0;
    end else begin
      req_valid <= 1'b0;
      if (frame_end) begin
        state <= ST_IDLE;
      end else if (byte_valid) begin
        unique case (state)
          ST_IDLE: begin
            if (is_row) begin
              plane_q <= byte_data[5];
              row_q   <= hdr_row;
              state   <= ST_ROW;
            end
          end
          ST_ROW, ST_DATA: begin
            if (is_row) begin
              plane_q <= byte_data[5];
              row_q   <= hdr_row;
              state   <= ST_ROW;
            end else begin
              col_q <= hdr_col;
              d8_q  <= byte_data[5] && !plane_q;
              state <= is_burst ? ST_BURST : ST_COL;
            end
          end
          ST_COL: begin
            req_valid <= 1'b1;
            req_cmd   <= '{plane: plane_q, row: row_q, col: col_q,
                           data: {d8_q, byte_data}};
            state     <= ST_DATA;
          end
          ST_BURST: begin
            req_valid <= 1'b1;
            req_cmd   <= '{plane: plane_q, row: row_q, col: col_q,
                           data: {d8_q, byte_data}};
            col_q     <= col_q + 1'b1;
            if (col_q == COL_LAST) row_q <= row_q + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rc_wr_stage.sv
module rc_wr_stage
  import rc_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  wr_cmd_t in_cmd,
  output logic    out_valid,
  input  logic    out_ready,
  output wr_cmd_t out_cmd
);

  logic load;

  assign load = in_valid && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cmd   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_cmd   <= in_cmd;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rc_cmd_decoder.sv
module rc_cmd_decoder
  import rc_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sel_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_plane,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data
);

  logic              byte_valid;
  logic [BYTE_W-1:0] byte_data;
  logic              frame_end;
  logic              req_valid;
  wr_cmd_t           req_cmd;
  fmt_state_e        fsm_state;
  wr_cmd_t           out_cmd;

  rc_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sel_n  (spi_sel_n),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .frame_end  (frame_end)
  );

  rc_fmt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .frame_end  (frame_end),
    .req_valid  (req_valid),
    .req_cmd    (req_cmd),
    .state      (fsm_state)
  );

  rc_wr_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_cmd    (req_cmd),
    .out_valid (wr_valid),
    .out_ready (wr_ready),
    .out_cmd   (out_cmd)
  );

  assign wr_plane = out_cmd.plane;
  assign wr_row   = out_cmd.row;
  assign wr_col   = out_cmd.col;
  assign wr_data  = out_cmd.data;

endmodule

// File: rtl/rc_cmd_decoder_chk.sv
module rc_cmd_decoder_chk
  import rc_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_plane,
  input logic [ROW_W-1:0]  wr_row,
  input logic [COL_W-1:0]  wr_col,
  input logic [DATA_W-1:0] wr_data,
  input fmt_state_e        fsm_state,
  input logic              req_valid,
  input logic              frame_end
);

  a_r11_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid);

  a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable({wr_plane, wr_row, wr_col, wr_data}));

  a_r12_keep_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && req_valid |=> $stable({wr_plane, wr_row, wr_col, wr_data}));

  a_r9_burst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_state == ST_BURST && !frame_end |=> fsm_state == ST_BURST);

  a_r2_frame_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> fsm_state == ST_IDLE);

  a_r6_req_after_column: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> fsm_state == ST_DATA || fsm_state == ST_BURST);

endmodule

bind rc_cmd_decoder rc_cmd_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_plane  (wr_plane),
  .wr_row    (wr_row),
  .wr_col    (wr_col),
  .wr_data   (wr_data),
  .fsm_state (fsm_state),
  .req_valid (req_valid),
  .frame_end (frame_end)
);

// File: tb/rc_cmd_decoder_tb.sv
module rc_cmd_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;

  typedef struct {
    logic       plane;
    logic [4:0] row;
    logic [4:0] col;
    logic [8:0] data;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sel_n = 1'b1;
  logic       spi_sck = 1'b0;
  logic       spi_mosi = 1'b0;
  logic       wr_ready = 1'b1;
  logic       wr_valid;
  logic       wr_plane;
  logic [4:0] wr_row;
  logic [4:0] wr_col;
  logic [8:0] wr_data;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_cmd_decoder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sel_n (spi_sel_n),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_plane  (wr_plane),
    .wr_row    (wr_row),
    .wr_col    (wr_col),
    .wr_data   (wr_data)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_wr(input logic pl, input logic [4:0] r, input logic [4:0] c,
                           input logic [8:0] d, input string tag);
    exp_t e;
    e.plane = pl; e.row = r; e.col = c; e.data = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic spi_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = b[i];
      wait_clks(HALF_BIT);
      spi_sck = 1'b1;
      wait_clks(HALF_BIT);
      spi_sck = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    spi_bits(b, 8);
  endtask

  task automatic frame_open();
    spi_sel_n = 1'b0;
    wait_clks(HALF_BIT);
  endtask

  task automatic frame_close();
    wait_clks(HALF_BIT);
    spi_sel_n = 1'b1;
    wait_clks(2 * HALF_BIT);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #1 wr_ready = v;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare every accepted write with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R10/R12", "unexpected write",
              {wr_plane, wr_row, wr_col, wr_data}, 0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({wr_plane, wr_row, wr_col, wr_data} == {e.plane, e.row, e.col, e.data},
              t, "write {plane,row,col,data}",
              {wr_plane, wr_row, wr_col, wr_data}, {e.plane, e.row, e.col, e.data});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_clks(5);
    // R1: reset state
    check(wr_valid == 1'b0, "R1", "wr_valid in reset", wr_valid, 0);
    rst_n = 1'b1;
    wait_clks(10);
    check(wr_valid == 1'b0, "R1", "wr_valid after reset", wr_valid, 0);

    // R3: non-row bytes in the initial state are ignored; R4/R5/R6 single shape
    frame_open();
    send_byte(8'h17);
    send_byte(8'h42);
    send_byte(8'h8E);           // row 14, character plane
    send_byte(8'h20);           // column 0, d8 = 1
    expect_wr(1'b0, 5'd14, 5'd0, 9'h142, "R5");
    send_byte(8'h42);
    send_byte(8'h81);           // row 1
    send_byte(8'h03);           // column 3, d8 = 0
    expect_wr(1'b0, 5'd1, 5'd3, 9'h0FF, "R6");
    send_byte(8'hFF);
    // R4/R6: per-column shape keeps the row
    send_byte(8'h27);           // column 7, d8 = 1
    expect_wr(1'b0, 5'd1, 5'd7, 9'h111, "R4");
    send_byte(8'h11);
    frame_close();

    // R3/R5: attribute plane, column bit 5 does not reach data bit 8
    frame_open();
    send_byte(8'hA2);
    send_byte(8'h25);
    expect_wr(1'b1, 5'd2, 5'd5, 9'h05A, "R3");
    send_byte(8'h5A);
    frame_close();

    // R7/R8: burst with column wrap and a data byte with bit 7 set
    frame_open();
    send_byte(8'h83);           // row 3
    send_byte(8'h7E);           // burst, column 30, d8 = 1
    expect_wr(1'b0, 5'd3, 5'd30, 9'h1A5, "R7");
    send_byte(8'hA5);
    expect_wr(1'b0, 5'd3, 5'd31, 9'h181, "R8");
    send_byte(8'h81);
    expect_wr(1'b0, 5'd4, 5'd0, 9'h13C, "R7");
    send_byte(8'h3C);
    expect_wr(1'b0, 5'd4, 5'd1, 9'h106, "R9");
    send_byte(8'h06);
    frame_close();

    // R9/R2: after the burst frame ends, a single shape works again
    frame_open();
    send_byte(8'h90);
    send_byte(8'h1F);
    expect_wr(1'b0, 5'd16, 5'd31, 9'h099, "R2");
    send_byte(8'h99);
    frame_close();

    // R10: partial byte then a fresh frame starting with non-row bytes
    frame_open();
    send_byte(8'h85);
    send_byte(8'h02);
    spi_bits(8'hFF, 4);
    frame_close();
    frame_open();
    send_byte(8'h05);
    send_byte(8'h33);
    frame_close();
    wait_clks(40);
    check(exp_q.size() == 0 && !wr_valid, "R10", "no write after partial byte",
          wr_valid, 0);

    // R11: stall holds the write on the port
    set_ready(1'b0);
    frame_open();
    send_byte(8'hA9);
    send_byte(8'h04);
    expect_wr(1'b1, 5'd9, 5'd4, 9'h0C3, "R11");
    send_byte(8'hC3);
    frame_close();
    wait_clks(30);
    check(wr_valid == 1'b1, "R11", "wr_valid held", wr_valid, 1);
    check({wr_plane, wr_row, wr_col, wr_data} == {1'b1, 5'd9, 5'd4, 9'h0C3},
          "R11", "fields held", {wr_plane, wr_row, wr_col, wr_data},
          {1'b1, 5'd9, 5'd4, 9'h0C3});
    set_ready(1'b1);
    wait_clks(10);

    // R12: second write while the first is pending is dropped
    set_ready(1'b0);
    frame_open();
    send_byte(8'h8A);
    send_byte(8'h01);
    expect_wr(1'b0, 5'd10, 5'd1, 9'h011, "R12");
    send_byte(8'h11);
    send_byte(8'h02);
    send_byte(8'h22);
    frame_close();
    wait_clks(20);
    check(wr_row == 5'd10 && wr_col == 5'd1, "R12", "pending write kept",
          {wr_row, wr_col}, {5'd10, 5'd1});
    set_ready(1'b1);
    wait_clks(40);

    check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule